// File: doc/BRIEF.md
# Shadowed Display Clock Divider Bank

This block holds fourteen integer clock dividers, seven for each of two display channels (main and auxiliary). Each channel has one divider for each destination: VGA output, picture path, TV encoder, HDMI pixel/PNX, HDMI, output interface and layer logic. Every divider produces a one-cycle clock-enable pulse derived from the common source clock `clk_i`.

Software stages new divider codes in shadow storage. It can use two masked word registers or a direct per-divider field write. Staged codes do not disturb the running dividers. They take effect only after the update flag changes from clear to set. Each divider then picks up its staged code at its own next terminal count, so a period already in progress always runs to its full length.

Top module: `disp_clkdiv_bank`

## Requirements
- R1: After reset, all shadow and active codes are 0 and the update flag is clear, so every bit of `clk_en_o` is high on every cycle.
- R2: A divider whose active code is N raises its enable for one cycle out of every N+1 cycles; code 0 keeps the enable high continuously.
- R3: Register 0 (`reg_addr_i`=0) holds four codes: main VGA in bits [2:0], main picture in [5:3], aux VGA in [8:6] and aux picture in [11:9]. Only bits set in `reg_wmask_i` are written.
- R4: Register 1 holds ten codes. The main channel's TV encoder, HDMI PNX, HDMI, interface and layer codes sit in [2:0], [5:3], [8:6], [11:9] and [14:12]. The aux channel's codes for the same five destinations, in the same order, sit in [17:15] through [29:27]. Bit 31 is the update flag. A single masked write may change fields and the flag together.
- R5: A field write sets one shadow code. The divider is chosen by `fld_id_i`: 0 VGA, 1 picture, 2 TV encoder, 3 HDMI PNX, 4 HDMI, 5 interface, 6 layer. The channel is chosen by `fld_chan_i`: 0 main, 1 aux. The divider drives `clk_en_o[fld_chan_i*7 + fld_id_i]`.
- R6: A field write with `fld_id_i` from 7 to 15 changes no shadow code.
- R7: Writes to shadow codes leave the active dividers and their enable outputs unchanged until an update is triggered.
- R8: An update is triggered only when the flag goes from 0 to 1. Writing 1 to a flag that is already 1 triggers nothing.
- R9: After a trigger, each divider finishes its current period with the old code. It loads the shadow code at that period's terminal count, and the next period uses the new code.
- R10: When a register write and a field write arrive in the same cycle, the register write is applied and the field write is dropped.
- R11: Clearing the update flag leaves the active codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select (0 or 1) |
| reg_wmask_i | input | 32 | Bit write mask |
| reg_wdata_i | input | 32 | Write data |
| fld_we_i | input | 1 | Field write strobe |
| fld_chan_i | input | 1 | Field channel: 0 main, 1 aux |
| fld_id_i | input | 4 | Field divider identifier |
| fld_code_i | input | 3 | Field divider code |
| clk_en_o | output | 14 | Clock-enable pulses; index chan*7+id |

## Verification
Several rules are checked by assertions on every cycle. Active codes stay put unless a transfer is pending. A pending transfer starts only in the same cycle as a rising update flag, and it retires only on an enable cycle. An enable is followed by a low cycle for any non-zero code and by another high cycle for code 0. Other behaviours can only be shown by the bench's scenarios: the field positions in both registers, the mapping from identifier and channel to output, ignored identifiers, the priority of register writes over field writes, and the exact lengths of the old and new periods around a transfer.

// File: rtl/disp_clkdiv_pkg.sv
package disp_clkdiv_pkg;
  localparam int NUM_CHAN = 2;
  localparam int NUM_DIV  = 7;
  localparam int NUM_OUT  = NUM_CHAN * NUM_DIV;
  localparam int CODE_W   = 3;
  localparam int ID_W     = 4;
  localparam int REG_W    = 32;
  localparam int UPD_BIT  = 31;
  // destinations 0..1 live in register 0, the rest in register 1
  localparam int SEL_REG_DIVS = 2;
  localparam int PAR_REG_DIVS = NUM_DIV - SEL_REG_DIVS;

  typedef enum logic [ID_W-1:0] {
    DIV_VGA      = 4'd0,
    DIV_PIC      = 4'd1,
    DIV_TVENC    = 4'd2,
    DIV_HDMI_PNX = 4'd3,
    DIV_HDMI     = 4'd4,
    DIV_INTF     = 4'd5,
    DIV_LAYER    = 4'd6
  } div_id_e;

  function automatic int fld_reg(int id);
    return (id < SEL_REG_DIVS) ? 0 : 1;
  endfunction

  function automatic int fld_lsb(int chan, int id);
    if (id < SEL_REG_DIVS) return (chan * SEL_REG_DIVS + id) * CODE_W;
    return (chan * PAR_REG_DIVS + id - SEL_REG_DIVS) * CODE_W;
  endfunction
endpackage

// File: rtl/disp_clkdiv_regs.sv
module disp_clkdiv_regs
  import disp_clkdiv_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            reg_we_i,
  input  logic                            reg_addr_i,
  input  logic [REG_W-1:0]                reg_wmask_i,
  input  logic [REG_W-1:0]                reg_wdata_i,
  input  logic                            fld_we_i,
  input  logic                            fld_chan_i,
  input  logic [ID_W-1:0]                 fld_id_i,
  input  logic [CODE_W-1:0]               fld_code_i,
  output logic [NUM_OUT-1:0][CODE_W-1:0]  shadow_o,
  output logic                            upd_flag_o,
  output logic                            arm_o
);
  logic flag_q;
  logic flag_wr;

  assign flag_wr = reg_we_i && reg_addr_i && reg_wmask_i[UPD_BIT];
  // R8: only a clear-to-set transition arms the transfer
  assign arm_o      = flag_wr && reg_wdata_i[UPD_BIT] && !flag_q;
  assign upd_flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_wr) flag_q <= reg_wdata_i[UPD_BIT];
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_shadow
    localparam int  CHAN = o / NUM_DIV;
    localparam int  ID   = o % NUM_DIV;
    localparam int  LSB  = fld_lsb(CHAN, ID);
    localparam logic RSEL = logic'(fld_reg(ID));

    logic [CODE_W-1:0] sh_q;
    logic [CODE_W-1:0] msk;
    logic              reg_hit;
    logic              fld_hit;

    assign msk     = reg_wmask_i[LSB +: CODE_W];
    assign reg_hit = reg_we_i && (reg_addr_i == RSEL);
    // R10: register write wins; R6: ids >= NUM_DIV match no divider
    assign fld_hit = !reg_we_i && fld_we_i &&
                     (fld_chan_i == logic'(CHAN)) &&
                     (fld_id_i == ID_W'(ID));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sh_q <= '0;
      else if (reg_hit) sh_q <= (sh_q & ~msk) | (reg_wdata_i[LSB +: CODE_W] & msk);
      else if (fld_hit) sh_q <= fld_code_i;
    end

    assign shadow_o[o] = sh_q;
  end
endmodule

// File: rtl/disp_clkdiv_cnt.sv
module disp_clkdiv_cnt #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] shadow_i,
  input  logic              arm_i,
  output logic              en_o,
  output logic [CODE_W-1:0] act_o,
  output logic              pend_o
);
  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] act_q;
  logic              pend_q;
  logic              term;

  assign term   = (cnt_q == act_q);
  assign en_o   = term;
  assign act_o  = act_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (term) begin
      cnt_q <= '0;
      // R9: swap codes only at a period boundary
      if (pend_q) act_q <= shadow_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (arm_i) pend_q <= 1'b1;
    else if (term)  pend_q <= 1'b0;
  end
endmodule

// File: rtl/disp_clkdiv_bank.sv
module disp_clkdiv_bank
  import disp_clkdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_addr_i,
  input  logic [REG_W-1:0]   reg_wmask_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  input  logic               fld_we_i,
  input  logic               fld_chan_i,
  input  logic [ID_W-1:0]    fld_id_i,
  input  logic [CODE_W-1:0]  fld_code_i,
  output logic [NUM_OUT-1:0] clk_en_o
);
  logic [NUM_OUT-1:0][CODE_W-1:0] shadow;
  logic [NUM_OUT-1:0][CODE_W-1:0] act;
  logic [NUM_OUT-1:0]             pend;
  logic                           upd_flag;
  logic                           arm;

  disp_clkdiv_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wmask_i (reg_wmask_i),
    .reg_wdata_i (reg_wdata_i),
    .fld_we_i    (fld_we_i),
    .fld_chan_i  (fld_chan_i),
    .fld_id_i    (fld_id_i),
    .fld_code_i  (fld_code_i),
    .shadow_o    (shadow),
    .upd_flag_o  (upd_flag),
    .arm_o       (arm)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_div
    disp_clkdiv_cnt #(.CODE_W(CODE_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .shadow_i (shadow[o]),
      .arm_i    (arm),
      .en_o     (clk_en_o[o]),
      .act_o    (act[o]),
      .pend_o   (pend[o])
    );
  end
endmodule

// File: rtl/disp_clkdiv_bank_chk.sv
module disp_clkdiv_bank_chk
  import disp_clkdiv_pkg::*;
(
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           upd_flag_i,
  input logic [NUM_OUT-1:0]             pend_i,
  input logic [NUM_OUT-1:0][CODE_W-1:0] act_i,
  input logic [NUM_OUT-1:0]             en_i
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    a_r8_pend_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_i[o]) |-> $rose(upd_flag_i));

    a_r9_retire_on_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_i[o]) |-> $past(en_i[o]));

    a_r7_hold_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_i[o] |=> $stable(act_i[o]));

    a_r2_gap_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[o] && !pend_i[o] && act_i[o] != '0) |=> !en_i[o]);

    a_r2_code0_continuous: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[o] && !pend_i[o] && act_i[o] == '0) |=> en_i[o]);
  end
endmodule

bind disp_clkdiv_bank disp_clkdiv_bank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_flag_i (upd_flag),
  .pend_i     (pend),
  .act_i      (act),
  .en_i       (clk_en_o)
);

// File: tb/sim_disp_clkdiv_bank.sv
module sim_disp_clkdiv_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wmask = '0;
  logic [31:0] reg_wdata = '0;
  logic        fld_we = 1'b0;
  logic        fld_chan = 1'b0;
  logic [3:0]  fld_id = '0;
  logic [2:0]  fld_code = '0;
  logic [13:0] clk_en;

  always #2 clk = ~clk;

  disp_clkdiv_bank u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wmask_i(reg_wmask), .reg_wdata_i(reg_wdata),
    .fld_we_i(fld_we), .fld_chan_i(fld_chan), .fld_id_i(fld_id), .fld_code_i(fld_code),
    .clk_en_o(clk_en)
  );

  int n_chk = 0;
  int n_fail = 0;
  int sh_m[14];
  int act_m[14];
  bit flag_m = 1'b0;

  typedef struct { int idx; int gap; string tag; } exp_t;
  exp_t sb_q[$];
  bit mon_busy = 1'b0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // bench-side field layout, from R3/R4
  function automatic int m_reg(int o);
    return ((o % 7) < 2) ? 0 : 1;
  endfunction
  function automatic int m_lsb(int o);
    int c = o / 7;
    int i = o % 7;
    if (i < 2) return c * 6 + i * 3;
    return c * 15 + (i - 2) * 3;
  endfunction

  function automatic void model_reg(bit a, logic [31:0] m, logic [31:0] d);
    for (int o = 0; o < 14; o++) begin
      if (m_reg(o) == int'(a)) begin
        for (int b = 0; b < 3; b++)
          if (m[m_lsb(o) + b]) begin
            if (d[m_lsb(o) + b]) sh_m[o] = sh_m[o] | (1 << b);
            else                 sh_m[o] = sh_m[o] & ~(1 << b);
          end
      end
    end
    if (a && m[31]) begin
      if (d[31] && !flag_m) act_m = sh_m;
      flag_m = d[31];
    end
  endfunction

  task automatic reg_wr(bit a, logic [31:0] m, logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wmask = m; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    model_reg(a, m, d);
  endtask

  task automatic fld_wr(bit c, int id, int code);
    @(posedge clk); #1;
    fld_we = 1'b1; fld_chan = c; fld_id = 4'(id); fld_code = 3'(code);
    @(posedge clk); #1;
    fld_we = 1'b0;
    if (id < 7) sh_m[int'(c) * 7 + id] = code;
  endtask

  task automatic settle();
    repeat (20) @(posedge clk);
  endtask

  task automatic set_flag(bit v);
    reg_wr(1'b1, 32'h8000_0000, {v, 31'b0});
    settle();
  endtask

  task automatic commit();
    set_flag(1'b0);
    set_flag(1'b1);
  endtask

  task automatic expect_gap(int idx, string tag);
    exp_t e;
    e.idx = idx; e.gap = act_m[idx] + 1; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    @(posedge clk);
    while (sb_q.size() > 0 || mon_busy) @(posedge clk);
  endtask

  // monitor: pops expected periods and measures them on clk_en
  initial begin
    exp_t e;
    int w;
    int g;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        mon_busy = 1'b1;
        e = sb_q.pop_front();
        w = 0;
        while (!clk_en[e.idx] && w < 40) begin @(negedge clk); w++; end
        g = 0;
        do begin @(negedge clk); g++; end while (!clk_en[e.idx] && g < 40);
        check(g == e.gap, e.tag, $sformatf("period of enable %0d", e.idx), g, e.gap);
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int g;
    for (int o = 0; o < 14; o++) begin sh_m[o] = 0; act_m[o] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, all enables high
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(clk_en == 14'h3FFF, "R1", "enables after reset", int'(clk_en), 16'h3FFF);
    end
    expect_gap(0, "R1"); expect_gap(13, "R1"); drain();

    // R7: staged codes do not disturb running dividers
    fld_wr(1'b0, 0, 3);
    fld_wr(1'b1, 6, 5);
    settle();
    expect_gap(0, "R7"); expect_gap(13, "R7"); drain();

    // R2/R5: after rising flag, main VGA divides by 4, aux layer by 6
    commit();
    expect_gap(0, "R2"); expect_gap(13, "R5"); drain();

    // R8: writing 1 to a set flag triggers nothing
    fld_wr(1'b0, 1, 2);
    set_flag(1'b1);
    expect_gap(1, "R8"); drain();

    // R11: clearing the flag keeps active codes
    set_flag(1'b0);
    expect_gap(0, "R11"); expect_gap(13, "R11"); drain();
    set_flag(1'b1);
    expect_gap(1, "R8"); drain();

    // R6: unknown ids ignored
    fld_wr(1'b0, 7, 6);
    fld_wr(1'b1, 15, 4);
    fld_wr(1'b1, 9, 7);
    commit();
    for (int o = 0; o < 14; o++) expect_gap(o, "R6");
    drain();

    // R3: clock-select register layout
    reg_wr(1'b0, 32'h0000_0FFF, 32'(2 | (4 << 3) | (1 << 6) | (7 << 9)));
    commit();
    expect_gap(0, "R3"); expect_gap(1, "R3"); expect_gap(7, "R3"); expect_gap(8, "R3");
    drain();

    // R4: divider-parameter register layout, masked writes, flag in same word
    w = 32'(1 | (2 << 3) | (3 << 6) | (4 << 9) | (5 << 12) |
            (6 << 15) | (7 << 18) | (0 << 21) | (1 << 24) | (3 << 27));
    reg_wr(1'b1, 32'h3FFF_FFFF, w);
    reg_wr(1'b1, 32'h0000_01C0, 32'h0000_0180);
    set_flag(1'b0);
    reg_wr(1'b1, 32'h8000_0000 | (7 << 27), 32'h8000_0000 | (2 << 27));
    settle();
    for (int o = 2; o < 7; o++) expect_gap(o, "R4");
    for (int o = 9; o < 14; o++) expect_gap(o, "R4");
    drain();

    // R10: register write wins over a simultaneous field write
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 1'b1; reg_wmask = 32'(7 << 12); reg_wdata = 32'(1 << 12);
    fld_we = 1'b1; fld_chan = 1'b0; fld_id = 4'd0; fld_code = 3'd6;
    @(posedge clk); #1;
    reg_we = 1'b0; fld_we = 1'b0;
    model_reg(1'b1, 32'(7 << 12), 32'(1 << 12));
    commit();
    expect_gap(0, "R10"); expect_gap(6, "R10"); drain();

    // R9: period in progress completes with old code
    fld_wr(1'b0, 0, 3);
    commit();
    fld_wr(1'b0, 0, 1);
    set_flag(1'b0);
    @(negedge clk);
    while (!clk_en[0]) @(negedge clk);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 1'b1; reg_wmask = 32'h8000_0000; reg_wdata = 32'h8000_0000;
    @(posedge clk); #1;
    reg_we = 1'b0;
    model_reg(1'b1, 32'h8000_0000, 32'h8000_0000);
    g = 1;
    do begin @(negedge clk); g++; end while (!clk_en[0] && g < 40);
    check(g == 4, "R9", "last period with old code", g, 4);
    g = 0;
    do begin @(negedge clk); g++; end while (!clk_en[0] && g < 40);
    check(g == 2, "R9", "first period with new code", g, 2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule